// File: doc/BRIEF.md
# Serial EEPROM Command Interface

This block is the device side of a small serial EEPROM that stores 16-bit words. A host selects it with a chip-select line, clocks bits in on a serial clock and data input, and receives read data and status flags on a serial data output that carries its own output-enable. Every instruction is built from 8-bit units. An opcode unit comes first. READ, PROGRAM, write-all and status instructions then take an address unit, and PROGRAM and write-all also take a 16-bit data word.

The storage is an internal register array that comes out of reset in the erased state (all ones). Writes are gated in three ways: a write-enable latch that the host sets and clears, a write-lock input pin, and the rule that nothing new starts while a program operation is running. A program operation holds the ready output low for a fixed number of system clock cycles, set by a parameter. When the ready output goes high again, the array holds the new contents. Dropping chip-select cancels any instruction that is only partly shifted in, but a program operation that has already started runs to the end.

Top module: `ser_eeprom`

## Requirements
- R1: After reset, `ready` is 1, `do_en` is 0, the write-enable latch is clear, and every word reads 16'hFFFF.
- R2: READ (opcode 8'b1010_1000), followed by an address unit, returns the addressed word on `do_o`, most significant bit first. All units on `di` are also sent most significant bit first.
- R3: PROGRAM (8'b1010_0100), followed by address and data, writes the word only while the write-enable latch is set. Write-enable (8'b1010_0011) sets the latch. Write-disable (8'b1010_0000) clears it.
- R4: While `wr_lock` is 1, PROGRAM, write-all and erase-all leave every word unchanged.
- R5: Status (8'b1010_1001) takes a second unit whose top two bits select the flag placed on `do_o`. 2'b00 gives ready (0 = busy). 2'b10 gives write inhibit (1 when the latch is clear or `wr_lock` is 1). 2'b01 gives a flag that always reads 0.
- R6: An accepted write holds `ready` low for exactly PROG_CYCLES clock cycles. The new contents are readable after `ready` returns high.
- R7: Write-all (8'b1010_0001), followed by an address unit (ignored) and data, writes that data to every word.
- R8: Erase-all (8'b1010_0010) sets every word to 16'hFFFF.
- R9: Deasserting `cs` cancels a partial instruction and turns `do_en` off. The next instruction after reselection decodes normally.
- R10: The word address is the top ADDR_W bits of the address unit. With ADDR_W = 7, bit 0 of that unit is ignored.
- R11: An opcode whose top nibble is not 4'b1010, or whose low nibble is unassigned, is ignored. It produces no output and no write.
- R12: `di` is taken on rising `sk` edges and `do_o`/`do_en` change only after falling `sk` edges. For READ, output starts at the fall that follows the last address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; `sk` is oversampled by it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data input |
| wr_lock | input | 1 | Write lock; 1 blocks all writes |
| do_o | output | 1 | Serial data output |
| do_en | output | 1 | Output enable for `do_o` (0 = high impedance) |
| ready | output | 1 | 1 = idle, 0 = program operation running |

## Verification
The bench builds the block with ADDR_W = 7, so the address unit carries a trailing bit that must be ignored and the top word (127) can be tested. It uses PROG_CYCLES = 400, which is long enough that a complete status instruction fits inside one program operation. This lets the bench see the busy flag read 0 while a write is running, and then measure the exact length of the low period on `ready`.

// File: rtl/ser_eeprom_pkg.sv
// Shared types for the serial EEPROM: opcode classes, command-engine
// states and the kinds of pending write. Assumes 8-bit instruction units.
package ser_eeprom_pkg;

    typedef enum logic [2:0] {
        OP_READ, OP_PROG, OP_WRAL, OP_ERAL, OP_WREN, OP_WRDIS, OP_STAT, OP_NONE
    } op_e;

    typedef enum logic [2:0] {
        ST_OP, ST_ADR, ST_DIN, ST_LOAD, ST_DOUT, ST_STAT, ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        WK_ONE, WK_ALL, WK_ERASE
    } wk_e;

    localparam logic [3:0] OP_PREFIX = 4'b1010;

    // Maps a received opcode unit to its class; anything unknown is OP_NONE.
    function automatic op_e decode_op(input logic [7:0] b);
        if (b[7:4] != OP_PREFIX) return OP_NONE;
        case (b[3:0])
            4'b1000: return OP_READ;
            4'b0100: return OP_PROG;
            4'b0001: return OP_WRAL;
            4'b0010: return OP_ERAL;
            4'b0011: return OP_WREN;
            4'b0000: return OP_WRDIS;
            4'b1001: return OP_STAT;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ser_eeprom_sync.sv
// Input synchronizer for cs, sk and di. Passes the three inputs through
// STAGES flops and detects sk edges on the synchronized copy.
// Assumes sk is held at each level for several clk periods.
module ser_eeprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic sk_fall
);
    logic [2:0] chain [STAGES];
    logic       sk_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= {cs, sk, di};
                end
            end else begin : g_next
                // Later stages pass the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delayed synchronized sk, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_d <= 1'b0;
        else        sk_d <= chain[STAGES-1][1];
    end

    assign cs_s    = chain[STAGES-1][2];
    assign di_s    = chain[STAGES-1][0];
    assign sk_rise = chain[STAGES-1][1] & ~sk_d;
    assign sk_fall = ~chain[STAGES-1][1] & sk_d;

endmodule

// File: rtl/ser_eeprom_cmd.sv
// Command engine. Shifts in opcode, address and data units on sk rises,
// owns the write-enable latch, requests writes and drives the serial
// output on sk falls. Assumes synchronized inputs and single-cycle edges.
module ser_eeprom_cmd
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic              sk_rise,
    input  logic              sk_fall,
    input  logic              busy,
    input  logic              wp_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              launch,
    output wk_e               launch_kind,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data,
    output logic              wel,
    output logic              do_o,
    output logic              do_en
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_BYTE_BIT = CW'(7);
    localparam logic [CW-1:0] LAST_WORD_BIT = CW'(DATA_W - 1);

    st_e               st;
    op_e               op;
    logic [CW-1:0]     bitcnt;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] dsh;
    logic [ADDR_W-1:0] adr;
    logic [1:0]        stat_sel;
    logic [7:0]        unit_in;
    logic [DATA_W-1:0] word_in;
    logic              can_write;
    logic              flag;
    op_e               op_in;

    assign unit_in   = {sh[6:0], di_s};
    assign word_in   = {sh[DATA_W-2:0], di_s};
    assign op_in     = decode_op(unit_in);
    assign can_write = wel & ~wp_q & ~busy;
    assign rd_addr   = adr;

    // Selected status flag, evaluated live at each falling edge.
    always_comb begin
        case (stat_sel)
            2'b00:   flag = ~busy;
            2'b10:   flag = ~(wel & ~wp_q);
            default: flag = 1'b0;
        endcase
    end

    // Instruction sequencing, latch updates, write requests and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_OP;
            op          <= OP_NONE;
            bitcnt      <= '0;
            sh          <= '0;
            dsh         <= '0;
            adr         <= '0;
            stat_sel    <= 2'b00;
            wel         <= 1'b0;
            do_o        <= 1'b0;
            do_en       <= 1'b0;
            launch      <= 1'b0;
            launch_kind <= WK_ONE;
            launch_addr <= '0;
            launch_data <= '0;
        end else begin
            launch <= 1'b0;
            if (!cs_s) begin
                st     <= ST_OP;
                bitcnt <= '0;
                do_en  <= 1'b0;
                do_o   <= 1'b0;
            end else begin
                if (st == ST_LOAD) begin
                    dsh <= rd_data;
                    st  <= ST_DOUT;
                end
                if (sk_rise) begin
                    case (st)
                        ST_OP: begin
                            sh <= word_in;
                            if (bitcnt == LAST_BYTE_BIT) begin
                                bitcnt <= '0;
                                op     <= op_in;
                                case (op_in)
                                    OP_READ, OP_PROG, OP_WRAL, OP_STAT: st <= ST_ADR;
                                    OP_WREN: begin
                                        wel <= 1'b1;
                                        st  <= ST_DONE;
                                    end
                                    OP_WRDIS: begin
                                        wel <= 1'b0;
                                        st  <= ST_DONE;
                                    end
                                    OP_ERAL: begin
                                        launch      <= can_write;
                                        launch_kind <= WK_ERASE;
                                        launch_data <= '1;
                                        st          <= ST_DONE;
                                    end
                                    default: st <= ST_DONE;
                                endcase
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        ST_ADR: begin
                            sh <= word_in;
                            if (bitcnt == LAST_BYTE_BIT) begin
                                bitcnt <= '0;
                                adr    <= unit_in[7 -: ADDR_W];
                                case (op)
                                    OP_READ: st <= ST_LOAD;
                                    OP_STAT: begin
                                        stat_sel <= unit_in[7:6];
                                        st       <= ST_STAT;
                                    end
                                    default: st <= ST_DIN;
                                endcase
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        ST_DIN: begin
                            sh <= word_in;
                            if (bitcnt == LAST_WORD_BIT) begin
                                bitcnt      <= '0;
                                launch      <= can_write;
                                launch_kind <= (op == OP_WRAL) ? WK_ALL : WK_ONE;
                                launch_addr <= adr;
                                launch_data <= word_in;
                                st          <= ST_DONE;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sk_fall) begin
                    case (st)
                        ST_DOUT: begin
                            do_o  <= dsh[DATA_W-1];
                            dsh   <= {dsh[DATA_W-2:0], 1'b0};
                            do_en <= 1'b1;
                        end
                        ST_STAT: begin
                            do_o  <= flag;
                            do_en <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ser_eeprom_store.sv
// Word storage and program timer. Accepts a write request when idle,
// holds busy for PROG_CYCLES cycles, then commits to one word or to all
// words. Assumes PROG_CYCLES >= 1. Resets to the erased state.
module ser_eeprom_store
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  wk_e               launch_kind,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              commit
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TW    = $clog2(PROG_CYCLES + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(PROG_CYCLES - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [TW-1:0]     cnt;
    logic              p_all;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;

    // Program timer: capture the request, count down, pulse commit at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            commit <= 1'b0;
            cnt    <= '0;
            p_all  <= 1'b0;
            p_addr <= '0;
            p_data <= '0;
        end else begin
            commit <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    busy   <= 1'b0;
                    commit <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (launch) begin
                busy   <= 1'b1;
                cnt    <= T_LOAD;
                p_all  <= (launch_kind != WK_ONE);
                p_addr <= launch_addr;
                p_data <= launch_data;
            end
        end
    end

    genvar w;
    generate
        for (w = 0; w < DEPTH; w++) begin : g_word
            // One storage word: erased on reset, written on a matching commit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[w] <= '1;
                else if (commit && (p_all || p_addr == ADDR_W'(w)))
                    mem[w] <= p_data;
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ser_eeprom.sv
// Top of the serial EEPROM: synchronizer, command engine and storage.
// Assumes sk is much slower than clk and wr_lock changes only between
// instructions.
module ser_eeprom
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic wr_lock,
    output logic do_o,
    output logic do_en,
    output logic ready
);
    logic              cs_s, di_s, sk_rise, sk_fall;
    logic              wp_q;
    logic              busy, commit, launch, wel;
    wk_e               launch_kind;
    logic [ADDR_W-1:0] launch_addr, rd_addr;
    logic [DATA_W-1:0] launch_data, rd_data;

    // Registers the write-lock pin before it gates any write.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= 1'b0;
        else        wp_q <= wr_lock;
    end

    ser_eeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .sk_fall(sk_fall)
    );

    ser_eeprom_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s),
        .sk_rise(sk_rise), .sk_fall(sk_fall), .busy(busy), .wp_q(wp_q),
        .rd_data(rd_data), .rd_addr(rd_addr), .launch(launch),
        .launch_kind(launch_kind), .launch_addr(launch_addr),
        .launch_data(launch_data), .wel(wel), .do_o(do_o), .do_en(do_en)
    );

    ser_eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_kind(launch_kind),
        .launch_addr(launch_addr), .launch_data(launch_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .commit(commit)
    );

    assign ready = ~busy;

endmodule

// File: rtl/ser_eeprom_chk.sv
// Assertion checker for ser_eeprom, attached with bind. Watches the
// output enable, the ready timing and the write gating.
module ser_eeprom_chk #(
    parameter int PROG_CYCLES = 400
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic do_en,
    input logic ready,
    input logic wel,
    input logic wp_q,
    input logic commit
);
    int unsigned lowc;

    // Counts consecutive cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n || ready) lowc <= 0;
        else                 lowc <= lowc + 1;
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_en); // R9
    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wel)); // R3
    AST_WRITE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> !$past(wp_q)); // R4
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (lowc == PROG_CYCLES)); // R6
    AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> commit); // R6
    AST_COMMIT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $rose(ready)); // R6

endmodule

bind ser_eeprom ser_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .do_en(do_en), .ready(ready),
    .wel(wel), .wp_q(wp_q), .commit(commit)
);

// File: tb/sim_ser_eeprom.sv
// Directed bench for ser_eeprom: one task per scenario.
module sim_ser_eeprom;
    localparam int AW = 7;
    localparam int DW = 16;
    localparam int PC = 400;
    localparam int H  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, wr_lock = 1'b0;
    logic do_o, do_en, ready;
    int   checks = 0;
    int   errors = 0;
    int   lowcnt = 0;
    int   last_len = 0;

    always #4 clk = ~clk;

    ser_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .wr_lock(wr_lock), .do_o(do_o), .do_en(do_en), .ready(ready)
    );

    // Measures the length of each low period on ready.
    always @(negedge clk) begin
        if (rst_n && !ready) lowcnt++;
        else if (lowcnt != 0) begin
            last_len = lowcnt;
            lowcnt   = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_up(input logic b);
        di = b;
        wait_clk(H);
        sk = 1'b1;
        wait_clk(H);
    endtask

    task automatic bit_t(input logic b);
        sk_up(b);
        sk = 1'b0;
    endtask

    task automatic send8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_t(v[i]);
    endtask

    task automatic send16(input logic [15:0] v);
        for (int i = 15; i >= 0; i--) bit_t(v[i]);
    endtask

    task automatic sel_on();
        cs = 1'b1;
        wait_clk(H);
    endtask

    task automatic sel_off();
        sk = 1'b0;
        cs = 1'b0;
        wait_clk(H);
    endtask

    task automatic read_word(input logic [7:0] abyte, output logic [15:0] d, input bit edge_chk);
        sel_on();
        send8(8'hA8);
        for (int i = 7; i >= 1; i--) bit_t(abyte[i]);
        sk_up(abyte[0]);
        if (edge_chk) chk(do_en == 1'b0, "R12 no output before fall", do_en, 0);
        sk = 1'b0;
        wait_clk(6);
        d[15] = do_o;
        if (edge_chk) chk(do_en == 1'b1, "R12 output after fall", do_en, 1);
        for (int i = 14; i >= 0; i--) begin
            bit_t(1'b0);
            wait_clk(6);
            d[i] = do_o;
        end
        sel_off();
    endtask

    task automatic status_bit(input logic [1:0] sel, output logic b);
        sel_on();
        send8(8'hA9);
        send8({sel, 6'b0});
        wait_clk(6);
        b = do_o;
        sel_off();
    endtask

    task automatic cmd_only(input logic [7:0] op);
        sel_on();
        send8(op);
        sel_off();
    endtask

    task automatic write_cmd(input logic [7:0] op, input logic [7:0] abyte, input logic [15:0] d);
        sel_on();
        send8(op);
        send8(abyte);
        send16(d);
        sel_off();
    endtask

    task automatic wait_ready();
        int n = 0;
        wait_clk(4);
        while (!ready && n < 2000) begin
            wait_clk(1);
            n++;
        end
        wait_clk(4);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(do_en == 1'b0, "R1 do_en", do_en, 0);
        read_word({7'd0, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R1 word0", d, 16'hFFFF);
        read_word({7'd127, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R1 word127", d, 16'hFFFF);
    endtask

    task automatic t_latch_clear();
        logic [15:0] d;
        logic b;
        status_bit(2'b10, b);
        chk(b == 1'b1, "R5 inhibit before enable", b, 1);
        write_cmd(8'hA4, {7'd5, 1'b0}, 16'hA5C3);
        wait_clk(20);
        chk(ready == 1'b1, "R3 no program without enable", ready, 1);
        read_word({7'd5, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R3 word unchanged", d, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [15:0] d;
        logic b;
        cmd_only(8'hA3);
        status_bit(2'b10, b);
        chk(b == 1'b0, "R5 permitted after enable", b, 0);
        write_cmd(8'hA4, {7'd5, 1'b0}, 16'hA5C3);
        status_bit(2'b00, b);
        chk(b == 1'b0, "R5 busy during program", b, 0);
        wait_ready();
        chk(last_len == PC, "R6 busy length", last_len, PC);
        status_bit(2'b00, b);
        chk(b == 1'b1, "R5 ready after program", b, 1);
        read_word({7'd5, 1'b0}, d, 1'b1);
        chk(d == 16'hA5C3, "R2 read programmed word", d, 16'hA5C3);
        read_word({7'd6, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R2 neighbour untouched", d, 16'hFFFF);
    endtask

    task automatic t_lock();
        logic [15:0] d;
        logic b;
        wr_lock = 1'b1;
        status_bit(2'b10, b);
        chk(b == 1'b1, "R5 inhibit while locked", b, 1);
        write_cmd(8'hA4, {7'd6, 1'b0}, 16'h1111);
        cmd_only(8'hA2);
        wait_clk(20);
        chk(ready == 1'b1, "R4 no write while locked", ready, 1);
        read_word({7'd6, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R4 word6 unchanged", d, 16'hFFFF);
        read_word({7'd5, 1'b0}, d, 1'b0);
        chk(d == 16'hA5C3, "R4 word5 survives erase-all", d, 16'hA5C3);
        wr_lock = 1'b0;
        wait_clk(4);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        sel_on();
        send8(8'hA4);
        for (int i = 0; i < 4; i++) bit_t(1'b1);
        sel_off();
        chk(do_en == 1'b0, "R9 quiet after abort", do_en, 0);
        sel_on();
        send8(8'hA8);
        send8({7'd5, 1'b0});
        bit_t(1'b0);
        bit_t(1'b0);
        sel_off();
        chk(do_en == 1'b0, "R9 output off after deselect", do_en, 0);
        read_word({7'd5, 1'b0}, d, 1'b0);
        chk(d == 16'hA5C3, "R9 next instruction decodes", d, 16'hA5C3);
    endtask

    task automatic t_addr_lsb();
        logic [15:0] d;
        read_word({7'd5, 1'b1}, d, 1'b0);
        chk(d == 16'hA5C3, "R10 address bit 0 ignored", d, 16'hA5C3);
    endtask

    task automatic t_ecc();
        logic b;
        status_bit(2'b01, b);
        chk(b == 1'b0, "R5 constant flag", b, 0);
    endtask

    task automatic t_wral();
        logic [15:0] d;
        write_cmd(8'hA1, 8'h00, 16'h1234);
        wait_ready();
        read_word({7'd0, 1'b0}, d, 1'b0);
        chk(d == 16'h1234, "R7 word0", d, 16'h1234);
        read_word({7'd127, 1'b0}, d, 1'b0);
        chk(d == 16'h1234, "R7 word127", d, 16'h1234);
    endtask

    task automatic t_eral();
        logic [15:0] d;
        cmd_only(8'hA2);
        wait_ready();
        read_word({7'd0, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R8 word0", d, 16'hFFFF);
        read_word({7'd64, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R8 word64", d, 16'hFFFF);
    endtask

    task automatic t_bad_op();
        logic [15:0] d;
        sel_on();
        send8(8'hB4);
        send8({7'd3, 1'b0});
        send16(16'h0000);
        wait_clk(6);
        chk(do_en == 1'b0, "R11 no output", do_en, 0);
        chk(ready == 1'b1, "R11 no write", ready, 1);
        sel_off();
        write_cmd(8'hAC, {7'd3, 1'b0}, 16'h0000);
        wait_clk(20);
        read_word({7'd3, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R11 word3 unchanged", d, 16'hFFFF);
    endtask

    task automatic t_disable();
        logic [15:0] d;
        cmd_only(8'hA0);
        write_cmd(8'hA4, {7'd9, 1'b0}, 16'h0F0F);
        wait_clk(20);
        read_word({7'd9, 1'b0}, d, 1'b0);
        chk(d == 16'hFFFF, "R3 disabled again", d, 16'hFFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_latch_clear();
        t_program();
        t_lock();
        t_abort();
        t_addr_lsb();
        t_ecc();
        t_wral();
        t_eral();
        t_bad_op();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule